// File: doc/BRIEF.md
# ADC User Channel Sequencer

This block is the sequencing core of a multi-channel ADC controller. Configuration writes give it a 16-bit enable mask, through separate set and clear ports, plus two 32-bit slot registers, a mode word and an extended-mode word. Each start, from an external trigger or from free-run mode, walks every enabled slot once. The walk goes from the lowest slot index to the highest. For each slot the block asks the converter for a conversion on a physical channel.

With slot mapping off, each enabled bit names its own channel. With slot mapping on, each enabled bit names a slot, and that slot's 4-bit field gives the channel. The same channel may therefore be converted several times in one pass, for example 7,7,6,6. Each result leaves as a 16-bit word. The channel number can sit in the upper nibble, and a one-cycle end strobe follows the last word of the pass. A prescaler derives the converter clock from the block clock.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, `conv_req`, `out_valid` and `eos` are low and the enable mask is empty, so a trigger produces no conversion.
- R2: With slot mapping off (mode bit 31 clear), every enabled bit k requests channel k, in ascending k.
- R3: With slot mapping on (mode bit 31 set), enabled slot k requests the 4-bit field at bits 4*(k mod 8) of the low slot register for k < 8, or of the high slot register for k >= 8.
- R4: One pass makes exactly as many conversions as the mask has set bits, in ascending slot order, and the same channel may repeat.
- R5: Fields of slots whose enable bit is clear have no effect on the requested channels.
- R6: A set write ORs its data into the mask and a clear write removes its data bits; a clear write of all ones empties the mask.
- R7: `conv_req` stays high with `conv_chan` stable until `conv_done`; each `conv_done` yields exactly one `out_valid` word on the next cycle.
- R8: When extended-mode bit 24 is set, `out_word` is {channel[3:0], sample[11:0]}; when it is clear, the upper nibble is zero.
- R9: `eos` pulses for one cycle, in the cycle after the last `out_valid` of a pass; an empty mask gives neither conversions nor `eos`.
- R10: With mode bit 7 set, a new pass starts right after the previous one ends, with no trigger.
- R11: `conv_clk` toggles every (P+1) block clocks, where P is mode bits 15:8, giving a period of 2*(P+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_set_we | input | 1 | OR `mask_wdata` into the enable mask |
| mask_clr_we | input | 1 | Clear the `mask_wdata` bits from the enable mask |
| mask_wdata | input | 16 | Mask write data |
| seq_lo_we | input | 1 | Write slot register for slots 0..7 |
| seq_hi_we | input | 1 | Write slot register for slots 8..15 |
| seq_wdata | input | 32 | Slot register write data |
| mode_we | input | 1 | Write mode word |
| mode_wdata | input | 32 | Mode word: bit 31 slot mapping, bit 7 free run, bits 15:8 prescale |
| ext_we | input | 1 | Write extended-mode word |
| ext_wdata | input | 32 | Extended-mode word: bit 24 channel tag enable |
| trigger | input | 1 | Start a pass when idle |
| conv_done | input | 1 | Converter finished, sample valid |
| conv_sample | input | 12 | Converter result |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 4 | Physical channel to convert |
| conv_clk | output | 1 | Divided converter clock |
| out_valid | output | 1 | Result word valid |
| out_word | output | 16 | Tagged result word |
| eos | output | 1 | End of pass strobe |

## Verification
The assertions assume that `conv_done` is a single-cycle pulse given only while `conv_req` is high. They also assume that mask, slot and mode registers are not rewritten while a pass is running, and that set and clear mask writes never come in the same cycle. The bench's converter model answers only an active request and drops `conv_done` after one cycle. All configuration writes happen between passes, with the trigger held low. Free-run is switched off and the bench lets the last pass drain before the next configuration is written.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NUM_SLOTS    = 16;
    localparam int SLOT_W       = $clog2(NUM_SLOTS);
    localparam int CH_W         = 4;
    localparam int SMP_W        = 12;
    localparam int PRE_W        = 8;
    localparam int WORD_W       = CH_W + SMP_W;
    localparam int SLOTS_PER_REG = 32 / CH_W;
    localparam int MAP_W        = NUM_SLOTS * CH_W;

    localparam int MODE_MAP_BIT  = 31;
    localparam int MODE_FREE_BIT = 7;
    localparam int MODE_PRE_LSB  = 8;
    localparam int EXT_TAG_BIT   = 24;

    typedef logic [CH_W-1:0]      chan_t;
    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [NUM_SLOTS-1:0] mask_t;

    typedef struct packed {
        logic             map_en;
        logic             free_run;
        logic             tag_en;
        logic [PRE_W-1:0] presc;
    } cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_END} walk_st_e;

    function automatic slot_t lowest_slot(input mask_t m);
        slot_t r;
        r = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (m[i]) r = slot_t'(i);
        end
        return r;
    endfunction

    function automatic chan_t slot_chan(input logic [MAP_W-1:0] map,
                                        input slot_t s, input logic map_en);
        if (map_en) return map[s*CH_W +: CH_W];
        return chan_t'(s);
    endfunction
endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_set_we,
    input  logic              mask_clr_we,
    input  logic [15:0]       mask_wdata,
    input  logic              seq_lo_we,
    input  logic              seq_hi_we,
    input  logic [31:0]       seq_wdata,
    input  logic              mode_we,
    input  logic [31:0]       mode_wdata,
    input  logic              ext_we,
    input  logic [31:0]       ext_wdata,
    output mask_t             mask,
    output logic [MAP_W-1:0]  map,
    output cfg_t              cfg
);
    logic [31:0] seq_lo_q, seq_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask     <= '0;
            seq_lo_q <= '0;
            seq_hi_q <= '0;
            cfg      <= '0;
        end else begin
            if (mask_set_we || mask_clr_we) begin
                mask <= (mask & ~(mask_clr_we ? mask_wdata : 16'h0))
                       | (mask_set_we ? mask_wdata : 16'h0);
            end
            if (seq_lo_we) seq_lo_q <= seq_wdata;
            if (seq_hi_we) seq_hi_q <= seq_wdata;
            if (mode_we) begin
                cfg.map_en   <= mode_wdata[MODE_MAP_BIT];
                cfg.free_run <= mode_wdata[MODE_FREE_BIT];
                cfg.presc    <= mode_wdata[MODE_PRE_LSB +: PRE_W];
            end
            if (ext_we) cfg.tag_en <= ext_wdata[EXT_TAG_BIT];
        end
    end

    assign map = {seq_hi_q, seq_lo_q};

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
        (mask_clr_we && !mask_set_we && mask_wdata == 16'hFFFF) |=> (mask == '0))
        else $error("R6 clear of all ones left mask bits set");
endmodule

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] presc,
    output logic          conv_clk
);
    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            conv_clk <= 1'b0;
        end else if (cnt_q >= presc) begin
            cnt_q    <= '0;
            conv_clk <= ~conv_clk;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assert_hold_level_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < presc) |=> $stable(conv_clk))
        else $error("R11 converter clock toggled early");
endmodule

// File: rtl/adc_seq_walker.sv
module adc_seq_walker
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mask_t             mask,
    input  logic [MAP_W-1:0]  map,
    input  cfg_t              cfg,
    input  logic              trigger,
    input  logic              conv_done,
    input  logic [SMP_W-1:0]  conv_sample,
    output logic              conv_req,
    output chan_t             conv_chan,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              eos
);
    walk_st_e state_q;
    mask_t    pend_q;
    mask_t    rest;

    assign rest      = pend_q & (pend_q - 1'b1);
    assign conv_req  = (state_q == ST_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pend_q    <= '0;
            conv_chan <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
            eos       <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            eos       <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if ((trigger || cfg.free_run) && mask != '0) begin
                        pend_q    <= mask;
                        conv_chan <= slot_chan(map, lowest_slot(mask), cfg.map_en);
                        state_q   <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (conv_done) begin
                        out_valid <= 1'b1;
                        out_word  <= {cfg.tag_en ? conv_chan : chan_t'(0), conv_sample};
                        pend_q    <= rest;
                        if (rest == '0) begin
                            state_q <= ST_END;
                        end else begin
                            conv_chan <= slot_chan(map, lowest_slot(rest), cfg.map_en);
                        end
                    end
                end
                default: begin
                    eos     <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)))
        else $error("R7 request dropped or channel moved before done");

    assert_done_gives_word_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_req && conv_done) |=> out_valid)
        else $error("R7 done without result word");

    assert_eos_after_word_R9: assert property (@(posedge clk) disable iff (rst)
        eos |-> $past(out_valid))
        else $error("R9 end strobe not preceded by a word");

    assert_eos_single_R9: assert property (@(posedge clk) disable iff (rst)
        eos |=> !eos)
        else $error("R9 end strobe longer than one cycle");

    assert_free_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (eos && cfg.free_run && mask != '0) |=> conv_req)
        else $error("R10 free run did not restart");
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mask_set_we,
    input  logic        mask_clr_we,
    input  logic [15:0] mask_wdata,
    input  logic        seq_lo_we,
    input  logic        seq_hi_we,
    input  logic [31:0] seq_wdata,
    input  logic        mode_we,
    input  logic [31:0] mode_wdata,
    input  logic        ext_we,
    input  logic [31:0] ext_wdata,
    input  logic        trigger,
    input  logic        conv_done,
    input  logic [11:0] conv_sample,
    output logic        conv_req,
    output logic [3:0]  conv_chan,
    output logic        conv_clk,
    output logic        out_valid,
    output logic [15:0] out_word,
    output logic        eos
);
    mask_t            mask;
    logic [MAP_W-1:0] map;
    cfg_t             cfg;

    adc_seq_cfg u_cfg (
        .clk(clk), .rst(rst),
        .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we), .mask_wdata(mask_wdata),
        .seq_lo_we(seq_lo_we), .seq_hi_we(seq_hi_we), .seq_wdata(seq_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ext_we(ext_we), .ext_wdata(ext_wdata),
        .mask(mask), .map(map), .cfg(cfg)
    );

    adc_seq_clkdiv #(.PW(PRE_W)) u_div (
        .clk(clk), .rst(rst), .presc(cfg.presc), .conv_clk(conv_clk)
    );

    adc_seq_walker u_walk (
        .clk(clk), .rst(rst), .mask(mask), .map(map), .cfg(cfg),
        .trigger(trigger), .conv_done(conv_done), .conv_sample(conv_sample),
        .conv_req(conv_req), .conv_chan(conv_chan),
        .out_valid(out_valid), .out_word(out_word), .eos(eos)
    );
endmodule

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mask_set_we = 0, mask_clr_we = 0, seq_lo_we = 0, seq_hi_we = 0;
    logic        mode_we = 0, ext_we = 0, trigger = 0, conv_done = 0;
    logic [15:0] mask_wdata = '0;
    logic [31:0] seq_wdata = '0, mode_wdata = '0, ext_wdata = '0;
    logic [11:0] conv_sample = '0;
    logic        conv_req, conv_clk, out_valid, eos;
    logic [3:0]  conv_chan;
    logic [15:0] out_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    adc_seq_top i_adc_seq_top (
        .clk(clk), .rst(rst),
        .mask_set_we(mask_set_we), .mask_clr_we(mask_clr_we), .mask_wdata(mask_wdata),
        .seq_lo_we(seq_lo_we), .seq_hi_we(seq_hi_we), .seq_wdata(seq_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ext_we(ext_we), .ext_wdata(ext_wdata),
        .trigger(trigger), .conv_done(conv_done), .conv_sample(conv_sample),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_clk(conv_clk),
        .out_valid(out_valid), .out_word(out_word), .eos(eos)
    );

    function automatic logic [11:0] smp_of(input logic [3:0] ch);
        return 12'h800 | (12'(ch) * 12'd37);
    endfunction

    // converter model and output monitor
    logic [15:0] rec [512];
    int rec_n = 0, eos_n = 0, done_n = 0, bad_eos = 0;
    int wcnt = 0;
    logic prev_valid = 0;
    always @(negedge clk) begin
        if (conv_done) begin
            conv_done <= 1'b0;
            wcnt      <= 0;
        end else if (conv_req) begin
            if (wcnt == 2) begin
                conv_done   <= 1'b1;
                conv_sample <= smp_of(conv_chan);
                done_n      <= done_n + 1;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
        if (out_valid) begin
            rec[rec_n % 512] <= out_word;
            rec_n <= rec_n + 1;
        end
        if (eos) begin
            eos_n <= eos_n + 1;
            if (!prev_valid) bad_eos <= bad_eos + 1;
        end
        prev_valid <= out_valid;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // which: 0 set, 1 clear, 2 seq lo, 3 seq hi, 4 mode, 5 ext
    task automatic wr(input int which, input logic [31:0] d);
        @(negedge clk);
        mask_wdata = d[15:0]; seq_wdata = d; mode_wdata = d; ext_wdata = d;
        mask_set_we = (which == 0); mask_clr_we = (which == 1);
        seq_lo_we = (which == 2); seq_hi_we = (which == 3);
        mode_we = (which == 4); ext_we = (which == 5);
        @(negedge clk);
        mask_set_we = 0; mask_clr_we = 0; seq_lo_we = 0; seq_hi_we = 0;
        mode_we = 0; ext_we = 0;
    endtask

    function automatic logic [31:0] mode_word(input bit map_en, input bit fr, input logic [7:0] p);
        return (32'(map_en) << 31) | (32'(fr) << 7) | (32'(p) << 8);
    endfunction

    int base_rec, base_eos, base_done;
    task automatic run_pass();
        base_rec = rec_n; base_eos = eos_n; base_done = done_n;
        @(negedge clk); trigger = 1;
        @(negedge clk); trigger = 0;
        for (int c = 0; c < 300 && eos_n == base_eos; c++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    localparam int NV = 5;
    localparam logic [15:0] V_MASK [NV] = '{16'h00C3, 16'h10C2, 16'h00C3, 16'h00F0, 16'h8001};
    localparam logic [31:0] V_LO   [NV] = '{32'h76000076, 32'h67000060, 32'h66AB0077, 32'h12345678, 32'h0000000F};
    localparam logic [31:0] V_HI   [NV] = '{32'h0, 32'h00070000, 32'h0, 32'h0, 32'h30000000};
    localparam logic        V_MAP  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [63:0] V_EXP  [NV] = '{64'h7676, 64'h7676, 64'h6677, 64'h7654, 64'h3F};

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!conv_req && !out_valid && !eos, "R1", "outputs after reset",
            {29'b0, conv_req, out_valid, eos}, 32'h0);
        run_pass();
        chk(rec_n == base_rec && eos_n == base_eos, "R1", "trigger with reset mask",
            rec_n - base_rec, 0);

        wr(5, 32'h0100_0000);
        for (int v = 0; v < NV; v++) begin
            wr(1, 32'hFFFF);
            wr(0, 32'(V_MASK[v]));
            wr(2, V_LO[v]);
            wr(3, V_HI[v]);
            wr(4, mode_word(V_MAP[v], 1'b0, 8'd0));
            run_pass();
            chk(rec_n - base_rec == $countones(V_MASK[v]), "R4", $sformatf("count vec %0d", v),
                rec_n - base_rec, $countones(V_MASK[v]));
            for (int k = 0; k < $countones(V_MASK[v]); k++) begin
                logic [3:0] ec;
                ec = V_EXP[v][4*k +: 4];
                chk(rec[(base_rec + k) % 512] == {ec, smp_of(ec)},
                    V_MAP[v] ? "R3/R5" : "R2", $sformatf("vec %0d word %0d", v, k),
                    32'(rec[(base_rec + k) % 512]), 32'({ec, smp_of(ec)}));
            end
            chk(eos_n - base_eos == 1 && bad_eos == 0, "R9", $sformatf("end strobe vec %0d", v),
                eos_n - base_eos, 1);
            chk(done_n - base_done == rec_n - base_rec, "R7", $sformatf("word per done vec %0d", v),
                rec_n - base_rec, done_n - base_done);
        end

        // R6: partial clear, then clear of all ones
        wr(1, 32'hFFFF); wr(0, 32'h00F0); wr(1, 32'h0030);
        wr(4, mode_word(1'b0, 1'b0, 8'd0));
        run_pass();
        chk(rec_n - base_rec == 2 && rec[base_rec % 512][15:12] == 4'd6
            && rec[(base_rec + 1) % 512][15:12] == 4'd7, "R6", "partial clear leaves 6,7",
            rec_n - base_rec, 2);
        wr(0, 32'h00FF); wr(1, 32'hFFFF);
        run_pass();
        chk(rec_n == base_rec, "R6", "clear all ones empties mask", rec_n - base_rec, 0);
        chk(eos_n == base_eos, "R9", "empty mask gives no end strobe", eos_n - base_eos, 0);

        // R8: tag off
        wr(5, 32'h0); wr(0, 32'h0200);
        run_pass();
        chk(rec_n - base_rec == 1 && rec[base_rec % 512] == {4'h0, smp_of(4'd9)}, "R8",
            "untagged word", 32'(rec[base_rec % 512]), 32'({4'h0, smp_of(4'd9)}));
        wr(5, 32'h0100_0000);

        // R10: free run
        wr(1, 32'hFFFF); wr(0, 32'h0003);
        base_eos = eos_n;
        wr(4, mode_word(1'b0, 1'b1, 8'd0));
        repeat (60) @(negedge clk);
        chk(eos_n - base_eos >= 2, "R10", "passes without trigger", eos_n - base_eos, 2);
        wr(4, mode_word(1'b0, 1'b0, 8'd0));
        repeat (30) @(negedge clk);
        base_eos = eos_n;
        repeat (30) @(negedge clk);
        chk(eos_n == base_eos, "R10", "free run stops", eos_n - base_eos, 0);

        // R11: prescaler
        wr(4, mode_word(1'b0, 1'b0, 8'd2));
        repeat (10) @(negedge clk);
        begin
            logic p;
            int n;
            p = conv_clk;
            for (int c = 0; c < 50 && conv_clk == p; c++) @(negedge clk);
            p = conv_clk; n = 0;
            for (int c = 0; c < 50 && conv_clk == p; c++) begin @(negedge clk); n++; end
            chk(n == 3, "R11", "half period for prescale 2", n, 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule